// File: doc/BRIEF.md
# Sector Erase Controller with Suspend and Resume

This block is the command engine of an emulated sector-erasable byte memory that sits on an 8-bit microcontroller bus. The bus has a chip select, an address, and separate write and read strobes. The engine decodes command bytes that are written to any address. A sector erase runs as a fixed number of clock cycles. It is preceded by a short start-up window, and all of its timing is counted in clock cycles. A read taken while the engine is busy returns a status byte in which one bit flips on every such read. Software polls that bit to see whether the engine is still working.

The erase can be frozen partway through with a suspend byte and restarted with a resume byte. While the erase is frozen, the rest of the array can be read, the partly erased sector reads as garbage, and nearly every command is refused. Each sector has a protection bit that is loaded from a configuration input. Bus software can read the protection bits but cannot change them. A program or erase aimed at a protected sector does nothing.

Top module: `erase_susp_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, the block is in read-array mode with no erase pending, the status toggle bit is 0, all protection bits are clear, and array byte i reads as i XOR 0xA5.
- R2: A read (cs and rd high at a clock edge) returns its byte on rdata with rvalid high exactly one cycle later. rvalid is low in every other cycle.
- R3: Writing 0x80 to an address in an unprotected sector starts an erase of that sector. The erase has a start-up window of TMO_CYC cycles followed by ERASE_CYC cycles of erasing. Every read during that time returns a status byte with bit 6 set to the toggle bit and all other bits 0, and each status read inverts the toggle. When the erase finishes, every byte of the sector reads 0xFF.
- R4: Writing 0xA0 arms a program. The next non-configuration write stores its data byte at its address, unless that data byte is 0xF0, which cancels the program.
- R5: Writing 0xB0 while no erase is in its start-up window or erasing has no effect. The next read returns array data, not status.
- R6: Writing 0xB0 during an erase leaves the block busy for SUSP_LAT more cycles, and status reads keep toggling during that time. The block then enters suspended read-array mode, and the toggle bit holds its value.
- R7: Writing 0xB0 during the start-up window cancels that window. After a later resume, the erase takes a full ERASE_CYC cycles.
- R8: While suspended, reads from the sector being erased return 0x00, and reads from any other sector return its stored data.
- R9: While suspended, only 0x30 (resume) and 0xF0 (reset) are accepted. Program and erase commands are ignored, and the erase cycle count stays frozen.
- R10: Writing 0x30 while suspended resumes the erase from its frozen cycle count. Status reads toggle again until the erase completes.
- R11: Writing 0xF0 while suspended abandons the erase and returns to read-array mode. The abandoned sector reads 0x00 until it is erased completely.
- R12: A pulse on prot_ld copies prot_cfg into the protection bits. A read with cfg_sel high returns those bits, with bit n for sector n. Writes with cfg_sel high change nothing. Erase and program commands aimed at a protected sector are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select for bus accesses |
| wr | input | 1 | Write strobe, sampled at the clock edge |
| rd | input | 1 | Read strobe, sampled at the clock edge |
| cfg_sel | input | 1 | Selects the read-only protection byte instead of the array |
| addr | input | AW | Byte address; the upper SW bits give the sector |
| wdata | input | 8 | Write data or command byte |
| prot_cfg | input | NUM_SECT | Protection pattern to load |
| prot_ld | input | 1 | Loads prot_cfg into the protection bits |
| rdata | output | 8 | Read data, status byte or protection byte |
| rvalid | output | 1 | rdata holds a fresh result this cycle |

## Verification
The hardest state to reach is the suspended erase, especially a suspend that lands inside the start-up window, and a suspend followed by an abandoning reset. The stimulus gets there by timing command writes a counted number of cycles after the erase byte. It places status reads inside the SUSP_LAT window to show that the toggle bit keeps running there. It then idles for longer than a full erase, showing the count stayed frozen, before it resumes and samples the completion cycle from both sides.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_PRG_ARM,
    ST_ER_WAIT,
    ST_ER_RUN,
    ST_SUSPING,
    ST_SUSP
  } esr_state_e;

  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  localparam logic [7:0] BAD_DATA   = 8'h00;
  localparam logic [7:0] ERASED     = 8'hFF;
  localparam logic [7:0] INIT_KEY   = 8'hA5;

  function automatic logic [7:0] status_byte(input logic t);
    return {1'b0, t, 6'b0};
  endfunction
endpackage

// File: rtl/esr_cmd_fsm.sv
module esr_cmd_fsm
  import esr_pkg::*;
#(
  parameter int NUM_SECT  = 8,
  parameter int TMO_CYC   = 8,
  parameter int ERASE_CYC = 64,
  parameter int SUSP_LAT  = 3,
  localparam int SW  = $clog2(NUM_SECT),
  localparam int TCW = $clog2(TMO_CYC + 1),
  localparam int ECW = $clog2(ERASE_CYC + 1),
  localparam int LCW = $clog2(SUSP_LAT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [7:0]          cmd_byte,
  input  logic [SW-1:0]       cmd_sect,
  input  logic [NUM_SECT-1:0] prot_q,
  output esr_state_e          state_o,
  output logic [SW-1:0]       er_sect_o,
  output logic [ECW-1:0]      ecnt_o,
  output logic                prog_we,
  output logic                erase_done,
  output logic                abandon
);
  esr_state_e     state;
  logic [SW-1:0]  er_sect;
  logic [TCW-1:0] tcnt;
  logic [ECW-1:0] ecnt;
  logic [LCW-1:0] lcnt;

  logic sect_prot, is_susp, is_resume, is_reset;
  assign sect_prot = prot_q[cmd_sect];
  assign is_susp   = cmd_wr && (cmd_byte == CMD_SUSP);
  assign is_resume = cmd_wr && (cmd_byte == CMD_RESUME);
  assign is_reset  = cmd_wr && (cmd_byte == CMD_RESET);

  assign prog_we    = (state == ST_PRG_ARM) && cmd_wr && !is_reset && !sect_prot;
  assign erase_done = (state == ST_ER_RUN) && !is_susp && (ecnt == ECW'(ERASE_CYC - 1));
  assign abandon    = (state == ST_SUSP) && is_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_READ;
      er_sect <= '0;
      tcnt    <= '0;
      ecnt    <= '0;
      lcnt    <= '0;
    end else begin
      case (state)
        ST_READ: begin
          if (cmd_wr && cmd_byte == CMD_PROG) begin
            state <= ST_PRG_ARM;
          end else if (cmd_wr && cmd_byte == CMD_ERASE && !sect_prot) begin
            state   <= ST_ER_WAIT;
            er_sect <= cmd_sect;
            tcnt    <= '0;
            ecnt    <= '0;
          end
        end
        ST_PRG_ARM: begin
          if (cmd_wr) state <= ST_READ;
        end
        ST_ER_WAIT: begin
          if (is_susp) begin
            state <= ST_SUSPING;
            lcnt  <= '0;
          end else if (tcnt == TCW'(TMO_CYC - 1)) begin
            state <= ST_ER_RUN;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_ER_RUN: begin
          if (is_susp) begin
            state <= ST_SUSPING;
            lcnt  <= '0;
          end else if (erase_done) begin
            state <= ST_READ;
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        ST_SUSPING: begin
          if (lcnt == LCW'(SUSP_LAT - 1)) state <= ST_SUSP;
          else lcnt <= lcnt + 1'b1;
        end
        ST_SUSP: begin
          if (is_resume)     state <= ST_ER_RUN;
          else if (is_reset) state <= ST_READ;
        end
        default: state <= ST_READ;
      endcase
    end
  end

  assign state_o   = state;
  assign er_sect_o = er_sect;
  assign ecnt_o    = ecnt;
endmodule

// File: rtl/esr_array.sv
module esr_array
  import esr_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int WPS      = 4,
  localparam int SW    = $clog2(NUM_SECT),
  localparam int WW    = $clog2(WPS),
  localparam int AW    = SW + WW,
  localparam int DEPTH = NUM_SECT * WPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_we,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          wdata,
  input  logic                erase_done,
  input  logic                abandon,
  input  logic [SW-1:0]       er_sect,
  input  logic                susp,
  input  logic                busy,
  input  logic                cfg_sel,
  input  logic                rd_req,
  input  logic [NUM_SECT-1:0] prot_q,
  output logic [7:0]          rdata,
  output logic                rvalid,
  output logic                tog
);
  logic [7:0]          mem [DEPTH];
  logic [NUM_SECT-1:0] inval;
  logic [SW-1:0]       rd_sect;
  logic [7:0]          prot_byte;

  assign rd_sect   = addr[AW-1:WW];
  assign prot_byte = 8'(prot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ INIT_KEY;
    end else begin
      if (prog_we) mem[addr] <= wdata;
      if (erase_done) begin
        for (int w = 0; w < WPS; w++) mem[{er_sect, WW'(w)}] <= ERASED;
      end
    end
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_inval
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  inval[s] <= 1'b0;
      else if (abandon && er_sect == SW'(s))       inval[s] <= 1'b1;
      else if (erase_done && er_sect == SW'(s))    inval[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      tog    <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) begin
        if (cfg_sel) begin
          rdata <= prot_byte;
        end else if (busy) begin
          rdata <= status_byte(tog);
          tog   <= ~tog;
        end else if (inval[rd_sect] || (susp && rd_sect == er_sect)) begin
          rdata <= BAD_DATA;
        end else begin
          rdata <= mem[addr];
        end
      end
    end
  end
endmodule

// File: rtl/erase_susp_ctrl.sv
module erase_susp_ctrl
  import esr_pkg::*;
#(
  parameter int NUM_SECT  = 8,
  parameter int WPS       = 4,
  parameter int TMO_CYC   = 8,
  parameter int ERASE_CYC = 64,
  parameter int SUSP_LAT  = 3,
  localparam int SW  = $clog2(NUM_SECT),
  localparam int WW  = $clog2(WPS),
  localparam int AW  = SW + WW,
  localparam int ECW = $clog2(ERASE_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                wr,
  input  logic                rd,
  input  logic                cfg_sel,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          wdata,
  input  logic [NUM_SECT-1:0] prot_cfg,
  input  logic                prot_ld,
  output logic [7:0]          rdata,
  output logic                rvalid
);
  logic                cmd_wr, rd_req;
  logic [SW-1:0]       cmd_sect, er_sect;
  logic [NUM_SECT-1:0] prot_q;
  esr_state_e          st;
  logic [ECW-1:0]      ecnt;
  logic                prog_we, erase_done, abandon, busy, susp, tog;

  assign cmd_wr   = cs && wr && !cfg_sel;
  assign rd_req   = cs && rd;
  assign cmd_sect = addr[AW-1:WW];
  assign busy     = (st == ST_ER_WAIT) || (st == ST_ER_RUN) || (st == ST_SUSPING);
  assign susp     = (st == ST_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= '0;
    else if (prot_ld) prot_q <= prot_cfg;
  end

  esr_cmd_fsm #(
    .NUM_SECT(NUM_SECT), .TMO_CYC(TMO_CYC),
    .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(wdata),
    .cmd_sect(cmd_sect), .prot_q(prot_q), .state_o(st),
    .er_sect_o(er_sect), .ecnt_o(ecnt), .prog_we(prog_we),
    .erase_done(erase_done), .abandon(abandon)
  );

  esr_array #(.NUM_SECT(NUM_SECT), .WPS(WPS)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .addr(addr),
    .wdata(wdata), .erase_done(erase_done), .abandon(abandon),
    .er_sect(er_sect), .susp(susp), .busy(busy), .cfg_sel(cfg_sel),
    .rd_req(rd_req), .prot_q(prot_q), .rdata(rdata), .rvalid(rvalid),
    .tog(tog)
  );
endmodule

// File: rtl/esr_checker.sv
module esr_checker
  import esr_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int ECW      = 7,
  localparam int SW = $clog2(NUM_SECT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs,
  input logic                wr,
  input logic                cfg_sel,
  input logic [7:0]          wdata,
  input logic                prot_ld,
  input logic [SW-1:0]       sect,
  input logic [NUM_SECT-1:0] prot_q,
  input esr_state_e          st,
  input logic [ECW-1:0]      ecnt,
  input logic                tog
);
  logic cw;
  assign cw = cs && wr && !cfg_sel;

  AST_PROT_ERASE_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && cw && wdata == 8'h80 && prot_q[sect]) |=> st == ST_READ); // R12
  AST_PROT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_ld |=> $stable(prot_q)); // R12
  AST_IDLE_SUSP_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && cw && wdata == 8'hB0) |=> st == ST_READ); // R5
  AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ER_RUN && cw && wdata == 8'hB0) |=> st == ST_SUSPING); // R6
  AST_TOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SUSP |=> $stable(tog)); // R6
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SUSP |=> ecnt == $past(ecnt)); // R9
  AST_RESUME_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP && cw && wdata == 8'h30) |=> st == ST_ER_RUN); // R10
endmodule

bind erase_susp_ctrl esr_checker #(.NUM_SECT(NUM_SECT), .ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .cfg_sel(cfg_sel),
  .wdata(wdata), .prot_ld(prot_ld), .sect(cmd_sect), .prot_q(prot_q),
  .st(st), .ecnt(ecnt), .tog(tog)
);

// File: tb/tb_erase_susp_ctrl.sv
module tb_erase_susp_ctrl;
  localparam int NS = 8, WPS = 4, TMO = 8, ERC = 64, LAT = 3;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic cs = 0, wr = 0, rd = 0, cfg_sel = 0, prot_ld = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [NS-1:0] prot_cfg = '0;
  logic [7:0] rdata;
  logic rvalid;

  always #10 clk = ~clk;

  erase_susp_ctrl #(.NUM_SECT(NS), .WPS(WPS), .TMO_CYC(TMO),
    .ERASE_CYC(ERC), .SUSP_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .cfg_sel(cfg_sel),
    .addr(addr), .wdata(wdata), .prot_cfg(prot_cfg), .prot_ld(prot_ld),
    .rdata(rdata), .rvalid(rvalid));

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  logic btog = 0;
  bit done = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic bus_write(input int a, input logic [7:0] d, input logic sel = 0);
    cs = 1; wr = 1; cfg_sel = sel; addr = AW'(a); wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; cfg_sel = 0;
  endtask

  task automatic bus_read(input int a, input logic [7:0] e, input string r, input logic sel = 0);
    item_t it;
    it.exp = e; it.req = r;
    sb.push_back(it);
    cs = 1; rd = 1; cfg_sel = sel; addr = AW'(a);
    @(negedge clk);
    cs = 0; rd = 0; cfg_sel = 0;
  endtask

  task automatic read_status(input int a, input string r);
    bus_read(a, {1'b0, btog, 6'b0}, r);
    btog = ~btog;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected rvalid, actual %02h expected none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s actual %02h expected %02h", it.req, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    checks++;
    if (rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset rvalid actual %b expected 0", rvalid);
    end
    // R1 reset contents, R2 one-cycle read latency
    bus_read(0, pat(0), "R1");
    bus_read(31, pat(31), "R2");
    bus_read(0, 8'h00, "R1_prot_clear", 1'b1);

    // R4 program
    bus_write(9, 8'hA0);
    bus_write(9, 8'h3C);
    bus_read(9, 8'h3C, "R4");
    bus_read(10, pat(10), "R4_neighbour");

    // R5 suspend with nothing running
    bus_write(0, 8'hB0);
    bus_read(0, pat(0), "R5");

    // R3 complete erase of sector 1
    bus_write(4, 8'h80);
    read_status(4, "R3");
    read_status(20, "R3");
    idle(TMO + ERC + 5);
    bus_read(4, 8'hFF, "R3");
    bus_read(7, 8'hFF, "R3");
    bus_read(9, 8'h3C, "R3_other");

    // R6 / R8 / R9 / R10 suspend during erase of sector 3
    bus_write(12, 8'h80);
    idle(TMO + 10);
    read_status(12, "R3");
    bus_write(12, 8'hB0);
    read_status(12, "R6");
    read_status(12, "R6");
    idle(4);
    bus_read(12, 8'h00, "R8");
    bus_read(13, 8'h00, "R8");
    bus_read(16, pat(16), "R8");
    bus_write(16, 8'hA0);
    bus_write(16, 8'h55);
    bus_read(16, pat(16), "R9");
    bus_write(20, 8'h80);
    bus_read(20, pat(20), "R9");
    idle(ERC + 20);
    bus_read(12, 8'h00, "R9");
    bus_write(12, 8'h30);
    read_status(12, "R10");
    idle(ERC + 5);
    bus_read(12, 8'hFF, "R10");
    bus_read(16, pat(16), "R10");

    // R7 suspend inside the start-up window
    bus_write(24, 8'h80);
    bus_write(24, 8'hB0);
    idle(LAT + TMO + 8);
    bus_read(24, 8'h00, "R7");
    bus_write(24, 8'h30);
    idle(ERC - 4);
    read_status(24, "R7");
    idle(5);
    bus_read(24, 8'hFF, "R7");

    // R11 reset while suspended
    bus_write(20, 8'h80);
    idle(TMO + 5);
    bus_write(20, 8'hB0);
    idle(LAT + 2);
    bus_write(20, 8'hF0);
    bus_read(20, 8'h00, "R11");
    bus_read(21, 8'h00, "R11");
    bus_read(28, pat(28), "R11");
    idle(ERC + 10);
    bus_read(22, 8'h00, "R11");
    bus_write(20, 8'h80);
    idle(TMO + ERC + 5);
    bus_read(20, 8'hFF, "R11");

    // R12 protection
    prot_cfg = 8'h80; prot_ld = 1;
    idle(1);
    prot_ld = 0;
    bus_read(0, 8'h80, "R12", 1'b1);
    bus_write(0, 8'h00, 1'b1);
    bus_read(0, 8'h80, "R12", 1'b1);
    bus_write(28, 8'h80);
    bus_read(28, pat(28), "R12");
    bus_write(29, 8'hA0);
    bus_write(29, 8'h00);
    bus_read(29, pat(29), "R12");

    idle(4);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2 pending reads actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule